// File: doc/BRIEF.md
# Calibrated Clock Prescaler

This block turns a 32,768 Hz oscillator enable, presented as a one-clock pulse in the system clock domain, into a one-second tick and a one-minute tick. It counts oscillator pulses in two stages: a first stage of 256 pulses, then enough first-stage periods to make up one second. Digital rate trim is applied at the boundary between these two stages.

Trim works inside a repeating frame of 64 minutes. A sign bit and a 5-bit magnitude N select how many minutes of the frame are corrected: the first 2N minutes, never more than the first 62. In each corrected minute, only the first second is changed. A positive sign shortens that second by 256 oscillator pulses, which speeds the clock up. A negative sign lengthens it by 128 pulses, which slows it down. One magnitude step is therefore worth about +4.07 ppm or -2.03 ppm. The calibration value is captured at the start of each frame, so every frame applies one consistent setting.

A run input freezes the whole chain. When the chain is released, the second in progress starts again from its beginning. A debug output shows the minute position inside the frame.

Top module: `calib_prescaler`

## Requirements
- R1: While reset is asserted and just after it is released, `sec_tick` and `min_tick` are 0 and `cyc_pos` is 0.
- R2: An uncorrected second lasts exactly OSC_HZ enable pulses. `sec_tick` is high for one clock, in the clock that follows the last pulse of the second.
- R3: `min_tick` rises together with every SEC_PER_MIN-th `sec_tick` and at no other time. On that clock `cyc_pos` advances by one, wrapping from MIN_PER_CYC-1 to 0. At all other times `cyc_pos` does not change.
- R4: With `cal_sign`=1, the first second of each corrected minute lasts OSC_HZ-POS_TRIM pulses.
- R5: With `cal_sign`=0, the first second of each corrected minute lasts OSC_HZ+NEG_TRIM pulses.
- R6: The corrected minutes are positions 0 to min(2*`cal_mag`, TRIM_MINUTES)-1 of the frame. A magnitude of 0 corrects no second, and every second outside those minutes is uncorrected.
- R7: The calibration inputs are captured on the first counted pulse of each frame. A change made during a frame takes effect only from the next frame.
- R8: While `run`=0, enable pulses are ignored: no tick is issued and `cyc_pos` holds.
- R9: When `run` returns to 1, the interrupted second is timed again from zero, so the next `sec_tick` comes after that second's full length in pulses.
- R10: Timing counts enable pulses only, so ticks do not depend on how many system clocks separate the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-clock pulse per oscillator cycle |
| run | input | 1 | 1 = count, 0 = freeze and clear the divider |
| cal_sign | input | 1 | 1 = shorten corrected seconds, 0 = lengthen them |
| cal_mag | input | MAG_W | Correction magnitude N; 2N minutes per frame are corrected |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| min_tick | output | 1 | One-clock pulse at the end of each minute |
| cyc_pos | output | CYC_W | Minute position inside the correction frame |

## Verification
The most crowded clock is the end of the last second of a frame. On that one clock, a second tick, a minute tick and the wrap of `cyc_pos` all fall together. The very next pulse then captures a new calibration value, and that value immediately decides the length of a corrected first second. The bench reaches this point by sweeping every sign and magnitude over two full frames in a reduced configuration, and by changing the calibration in the middle of a frame. Every tick interval is compared, in pulses, with a length computed from the frame position and the captured value. The pulse count and `cyc_pos` are also checked across the frame boundary, while the chain is stopped, and after it restarts.

// File: rtl/cps_pkg.sv
package cps_pkg;

   // Kind of correction applied to the second currently being timed.
   typedef enum logic [1:0] {
      TRIM_NONE  = 2'd0,
      TRIM_SHORT = 2'd1,
      TRIM_LONG  = 2'd2
   } trim_mode_e;

endpackage

// File: rtl/cps_divider.sv
// Two-stage pulse divider: a first stage of PRE_DIV pulses, then STAGES
// first-stage periods per second. A long trim stretches the first
// first-stage period; a short trim drops SKIP first-stage periods.
module cps_divider
   import cps_pkg::*;
#(
   parameter int PRE_DIV  = 256,
   parameter int STAGES   = 128,
   parameter int SKIP     = 1,
   parameter int NEG_TRIM = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       osc_en,
   input  trim_mode_e mode,
   output logic       at_start,
   output logic       sec_end
);

   localparam int PRE_W = $clog2(PRE_DIV + NEG_TRIM);
   localparam int STG_W = $clog2(STAGES);
   localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(PRE_DIV - 1);
   localparam logic [STG_W-1:0] STG_LAST  = STG_W'(STAGES - 1);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_lim;
   logic [STG_W-1:0] stg_q;
   logic [STG_W-1:0] stg_lim;
   logic             pre_wrap;
   logic             stg_wrap;

   // A negative trim stretches only the first first-stage period of the second.
   if (NEG_TRIM > 0) begin : g_long
      localparam logic [PRE_W-1:0] PRE_LONG = PRE_W'(PRE_DIV + NEG_TRIM - 1);
      always_comb begin
         if (mode == TRIM_LONG && stg_q == '0) pre_lim = PRE_LONG;
         else                                  pre_lim = PRE_LAST;
      end
   end else begin : g_nolong
      assign pre_lim = PRE_LAST;
   end

   // A positive trim ends the second SKIP first-stage periods early.
   if (SKIP > 0) begin : g_short
      localparam logic [STG_W-1:0] STG_SHORT = STG_W'(STAGES - SKIP - 1);
      always_comb begin
         if (mode == TRIM_SHORT) stg_lim = STG_SHORT;
         else                    stg_lim = STG_LAST;
      end
   end else begin : g_noshort
      assign stg_lim = STG_LAST;
   end

   assign pre_wrap = (pre_q == pre_lim);
   assign stg_wrap = (stg_q == stg_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         stg_q <= '0;
      end else if (!run) begin
         pre_q <= '0;
         stg_q <= '0;
      end else if (osc_en) begin
         if (pre_wrap) begin
            pre_q <= '0;
            if (stg_wrap) stg_q <= '0;
            else          stg_q <= stg_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   assign at_start = (pre_q == '0) && (stg_q == '0);
   assign sec_end  = run && osc_en && pre_wrap && stg_wrap;

endmodule

// File: rtl/cps_timebase.sv
// Second-in-minute and minute-in-frame counters with registered ticks.
module cps_timebase #(
   parameter int SEC_PER_MIN = 60,
   parameter int MIN_PER_CYC = 64,
   parameter int SEC_W       = 6,
   parameter int CYC_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_end,
   output logic [SEC_W-1:0] sec_idx,
   output logic [CYC_W-1:0] min_idx,
   output logic             at_origin,
   output logic             sec_tick,
   output logic             min_tick
);

   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
   localparam logic [CYC_W-1:0] MIN_LAST = CYC_W'(MIN_PER_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_idx  <= '0;
         min_idx  <= '0;
         sec_tick <= 1'b0;
         min_tick <= 1'b0;
      end else if (sec_end) begin
         sec_tick <= 1'b1;
         if (sec_idx == SEC_LAST) begin
            sec_idx  <= '0;
            min_tick <= 1'b1;
            if (min_idx == MIN_LAST) min_idx <= '0;
            else                     min_idx <= min_idx + 1'b1;
         end else begin
            sec_idx  <= sec_idx + 1'b1;
            min_tick <= 1'b0;
         end
      end else begin
         sec_tick <= 1'b0;
         min_tick <= 1'b0;
      end
   end

   assign at_origin = (sec_idx == '0) && (min_idx == '0);

endmodule

// File: rtl/cps_trim_ctrl.sv
// Captures the calibration setting at frame start and decides the trim
// applied to the current second.
module cps_trim_ctrl
   import cps_pkg::*;
#(
   parameter int MAG_W        = 5,
   parameter int TRIM_MINUTES = 62,
   parameter int SEC_W        = 6,
   parameter int CYC_W        = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             osc_en,
   input  logic             frame_start,
   input  logic             cal_sign,
   input  logic [MAG_W-1:0] cal_mag,
   input  logic [SEC_W-1:0] sec_idx,
   input  logic [CYC_W-1:0] min_idx,
   output trim_mode_e       mode
);

   localparam int TW = ((MAG_W + 1 > CYC_W) ? MAG_W + 1 : CYC_W) + 1;
   localparam logic [TW-1:0] TRIM_CAP = TW'(TRIM_MINUTES);

   logic             sign_q;
   logic [MAG_W-1:0] mag_q;
   logic             eff_sign;
   logic [MAG_W-1:0] eff_mag;
   logic [TW-1:0]    twice;
   logic [TW-1:0]    span;
   logic             active;

   // Capture on the first counted pulse of the frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_q <= 1'b0;
         mag_q  <= '0;
      end else if (run && osc_en && frame_start) begin
         sign_q <= cal_sign;
         mag_q  <= cal_mag;
      end
   end

   // At the frame start the live value already governs the first second.
   assign eff_sign = frame_start ? cal_sign : sign_q;
   assign eff_mag  = frame_start ? cal_mag  : mag_q;

   always_comb begin
      twice  = TW'({eff_mag, 1'b0});
      span   = (twice > TRIM_CAP) ? TRIM_CAP : twice;
      active = (sec_idx == '0) && (TW'(min_idx) < span);
      if (!active)      mode = TRIM_NONE;
      else if (eff_sign) mode = TRIM_SHORT;
      else               mode = TRIM_LONG;
   end

endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler
   import cps_pkg::*;
#(
   parameter int OSC_HZ       = 32768,
   parameter int PRE_DIV      = 256,
   parameter int SEC_PER_MIN  = 60,
   parameter int MIN_PER_CYC  = 64,
   parameter int TRIM_MINUTES = 62,
   parameter int POS_TRIM     = 256,
   parameter int NEG_TRIM     = 128,
   parameter int MAG_W        = 5,
   localparam int CYC_W       = $clog2(MIN_PER_CYC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_en,
   input  logic             run,
   input  logic             cal_sign,
   input  logic [MAG_W-1:0] cal_mag,
   output logic             sec_tick,
   output logic             min_tick,
   output logic [CYC_W-1:0] cyc_pos
);

   localparam int STAGES = OSC_HZ / PRE_DIV;
   localparam int SKIP   = POS_TRIM / PRE_DIV;
   localparam int SEC_W  = $clog2(SEC_PER_MIN);

   // Elaboration-time configuration checks.
   if (PRE_DIV < 2) begin : g_bad_pre
      $error("PRE_DIV must be at least 2");
   end
   if (OSC_HZ % PRE_DIV != 0 || STAGES < 2) begin : g_bad_osc
      $error("OSC_HZ must be a multiple of PRE_DIV giving at least 2 stages");
   end
   if (POS_TRIM % PRE_DIV != 0 || SKIP >= STAGES) begin : g_bad_pos
      $error("POS_TRIM must be a multiple of PRE_DIV shorter than a second");
   end
   if (NEG_TRIM < 0) begin : g_bad_neg
      $error("NEG_TRIM must not be negative");
   end
   if (SEC_PER_MIN < 2 || MIN_PER_CYC < 2) begin : g_bad_cnt
      $error("SEC_PER_MIN and MIN_PER_CYC must be at least 2");
   end
   if (TRIM_MINUTES > MIN_PER_CYC) begin : g_bad_trim
      $error("TRIM_MINUTES cannot exceed MIN_PER_CYC");
   end

   trim_mode_e       mode;
   logic             div_start;
   logic             sec_end;
   logic [SEC_W-1:0] sec_idx;
   logic [CYC_W-1:0] min_idx;
   logic             at_origin;

   cps_divider #(
      .PRE_DIV  (PRE_DIV),
      .STAGES   (STAGES),
      .SKIP     (SKIP),
      .NEG_TRIM (NEG_TRIM)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .osc_en   (osc_en),
      .mode     (mode),
      .at_start (div_start),
      .sec_end  (sec_end)
   );

   cps_timebase #(
      .SEC_PER_MIN (SEC_PER_MIN),
      .MIN_PER_CYC (MIN_PER_CYC),
      .SEC_W       (SEC_W),
      .CYC_W       (CYC_W)
   ) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_end   (sec_end),
      .sec_idx   (sec_idx),
      .min_idx   (min_idx),
      .at_origin (at_origin),
      .sec_tick  (sec_tick),
      .min_tick  (min_tick)
   );

   cps_trim_ctrl #(
      .MAG_W        (MAG_W),
      .TRIM_MINUTES (TRIM_MINUTES),
      .SEC_W        (SEC_W),
      .CYC_W        (CYC_W)
   ) u_trim (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .osc_en      (osc_en),
      .frame_start (div_start && at_origin),
      .cal_sign    (cal_sign),
      .cal_mag     (cal_mag),
      .sec_idx     (sec_idx),
      .min_idx     (min_idx),
      .mode        (mode)
   );

   assign cyc_pos = min_idx;

endmodule

// File: rtl/calib_prescaler_chk.sv
module calib_prescaler_chk #(
   parameter int MIN_PER_CYC = 64,
   parameter int CYC_W       = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_en,
   input logic             run,
   input logic             sec_tick,
   input logic             min_tick,
   input logic [CYC_W-1:0] cyc_pos
);

   localparam logic [CYC_W-1:0] POS_LAST = CYC_W'(MIN_PER_CYC - 1);

   // R2: a second tick lasts exactly one clock
   p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   // R3: a minute tick only comes with a second tick
   p_min_with_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick |-> sec_tick);

   // R3: the frame position steps by one on a minute tick
   p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick |-> (cyc_pos == (($past(cyc_pos) == POS_LAST) ? '0
                                 : $past(cyc_pos) + 1'b1)));

   // R3: the frame position holds between minute ticks
   p_pos_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !min_tick |-> $stable(cyc_pos));

   // R8: no tick follows a clock in which counting was stopped
   p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sec_tick);

   // R10: a tick only follows an enable pulse
   p_pulse_needed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> !sec_tick);

endmodule

bind calib_prescaler calib_prescaler_chk #(
   .MIN_PER_CYC (MIN_PER_CYC),
   .CYC_W       (CYC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .osc_en   (osc_en),
   .run      (run),
   .sec_tick (sec_tick),
   .min_tick (min_tick),
   .cyc_pos  (cyc_pos)
);

// File: tb/calib_prescaler_bench.sv
module calib_prescaler_bench;

   localparam int CLK_PERIOD = 10;
   localparam int OSC  = 16;
   localparam int PRE  = 4;
   localparam int SPM  = 3;
   localparam int MPC  = 8;
   localparam int ELIG = 4;
   localparam int POS  = 4;
   localparam int NEG  = 2;
   localparam int MW   = 2;
   localparam int FRAME_SECS = SPM * MPC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          osc_en = 1'b0;
   logic          run = 1'b0;
   logic          cal_sign = 1'b0;
   logic [MW-1:0] cal_mag = '0;
   logic          sec_tick;
   logic          min_tick;
   logic [2:0]    cyc_pos;

   calib_prescaler #(
      .OSC_HZ (OSC), .PRE_DIV (PRE), .SEC_PER_MIN (SPM), .MIN_PER_CYC (MPC),
      .TRIM_MINUTES (ELIG), .POS_TRIM (POS), .NEG_TRIM (NEG), .MAG_W (MW)
   ) u_calib_prescaler (
      .clk (clk), .rst_n (rst_n), .osc_en (osc_en), .run (run),
      .cal_sign (cal_sign), .cal_mag (cal_mag),
      .sec_tick (sec_tick), .min_tick (min_tick), .cyc_pos (cyc_pos)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int    n_chk = 0;
   int    n_fail = 0;
   int    osc_cnt = 0;
   int    last_mark = 0;
   int    tick_seen = 0;
   int    sidx = 0;
   int    midx = 0;
   bit    l_sign = 0;
   int    l_mag = 0;
   bit    pending = 1;
   int    osc_mode = 0;
   int    ph = 0;
   string req_over = "";

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_len(int s, int m, bit sg, int mg);
      int span;
      span = (2 * mg > ELIG) ? ELIG : 2 * mg;
      if (s == 0 && m < span) return sg ? OSC - POS : OSC + NEG;
      return OSC;
   endfunction

   // Enable pulse source: continuous, or one pulse every third clock.
   always @(negedge clk) begin
      if (osc_mode == 0) osc_en = 1'b1;
      else begin
         osc_en = (ph == 0);
         ph = (ph == 2) ? 0 : ph + 1;
      end
   end

   // Pulse counter; the model captures calibration on the frame's first pulse (R7).
   always @(posedge clk) begin
      if (rst_n && run && osc_en) begin
         if (pending) begin
            l_sign  = cal_sign;
            l_mag   = int'(cal_mag);
            pending = 0;
         end
         osc_cnt++;
      end
   end

   // Tick monitor and model.
   always @(negedge clk) begin
      if (rst_n && min_tick && !sec_tick) chk(0, "R3", 1, 0);
      if (rst_n && sec_tick) begin
         int    e;
         int    a;
         string tag;
         bit    wrap;
         e = exp_len(sidx, midx, l_sign, l_mag);
         a = osc_cnt - last_mark;
         if (req_over != "") tag = req_over;
         else if (e < OSC) tag = "R4";
         else if (e > OSC) tag = "R5";
         else if (sidx == 0 && midx < 2 * l_mag) tag = "R6";
         else tag = "R2";
         chk(a == e, tag, a, e);
         last_mark = osc_cnt;
         wrap = (sidx == SPM - 1);
         chk(min_tick == wrap, "R3", int'(min_tick), int'(wrap));
         if (wrap) begin
            sidx = 0;
            midx = (midx + 1) % MPC;
            if (midx == 0) pending = 1;
         end else begin
            sidx++;
         end
         chk(int'(cyc_pos) == midx, "R3", int'(cyc_pos), midx);
         tick_seen++;
      end
   end

   task automatic start(input bit sg, input int mg, input int mode);
      rst_n = 1'b0;
      run = 1'b1;
      osc_mode = mode;
      cal_sign = sg;
      cal_mag = MW'(mg);
      repeat (3) @(negedge clk);
      sidx = 0; midx = 0; pending = 1; last_mark = osc_cnt;
      rst_n = 1'b1;
   endtask

   task automatic wait_ticks(input int n);
      int target;
      target = tick_seen + n;
      while (tick_seen < target) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(sec_tick == 0, "R1", int'(sec_tick), 0);
      chk(min_tick == 0, "R1", int'(min_tick), 0);
      chk(cyc_pos == 0, "R1", int'(cyc_pos), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cyc_pos == 0 && !sec_tick, "R1", int'(cyc_pos), 0);

      // Sweep every sign and magnitude over two frames: R2 R4 R5 R6
      for (int sg = 0; sg < 2; sg++) begin
         for (int mg = 0; mg < (1 << MW); mg++) begin
            start(sg[0], mg, 0);
            wait_ticks(2 * FRAME_SECS);
         end
      end

      // R7: change calibration in mid-frame; the old value holds to frame end
      start(1'b1, 1, 0);
      wait_ticks(5);
      cal_sign = 1'b0;
      cal_mag = MW'(3);
      wait_ticks(2 * FRAME_SECS);

      // R10: sparse enable pulses
      start(1'b0, 2, 1);
      wait_ticks(FRAME_SECS + 4);

      // R8 and R9: stop in the middle of a second, then restart
      start(1'b1, 1, 0);
      while (!(midx == 1 && sidx == 1)) @(negedge clk);
      repeat (5) @(negedge clk);
      run = 1'b0;
      begin
         int held;
         int seen;
         held = int'(cyc_pos);
         seen = tick_seen;
         repeat (40) @(negedge clk);
         chk(tick_seen == seen, "R8", tick_seen - seen, 0);
         chk(int'(cyc_pos) == held, "R8", int'(cyc_pos), held);
      end
      last_mark = osc_cnt;
      req_over = "R9";
      run = 1'b1;
      wait_ticks(1);
      req_over = "";
      wait_ticks(FRAME_SECS);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule